// File: doc/BRIEF.md
# Partitioned Four-Way Cache Lookup

This block is a unified four-way set-associative cache with 64 sets of 16-byte lines. It sits between a CPU load/store port and a simple memory port. The top three bits of each request address choose how the access is handled. It can be a normal cached access, or an uncached single access that bypasses the arrays. It can also be a purge of one line selected by address, or a direct read or write of the tag array or the data array. The last two let software inspect or initialise the cache without going through memory.

Each request is captured in one pipeline register. During the next cycle the tag compare, the hit decision and the byte-lane extraction all take place. A hit answers in that cycle, so a stream of hits is served at one per cycle. A read miss asks memory for the whole line and then installs it. The victim is the lowest-numbered invalid way, or the pseudo-LRU way if none is invalid. Writes go through to memory. A write that hits also updates the cached copy, and a write that misses allocates nothing.

Top module: `pcache4`

## Requirements
- R1: Address bits 31:29 select the handling. Code 000 is cached when `cache_en` was 1 at acceptance. Codes 001, 111, 100, 101, and 000 with `cache_en` at 0, are uncached: each gives one single memory access (`mem_fill`=0) and never a line fill.
- R2: For codes 000 and 001, `mem_addr` carries the request address with bits 31:29 cleared. Both codes therefore reach the same physical location. For all other codes, `mem_addr` is the request address unchanged.
- R3: A cached access hits only in a way that is valid and whose stored tag equals address bits 28:10, within the set chosen by bits 9:4. A hit causes no memory access.
- R4: A request accepted at a clock edge that hits is answered with `rsp_valid` during the next cycle. Hits issued on consecutive cycles are accepted and answered on consecutive cycles, with `req_ready` held high.
- R5: A cached read miss issues one line fill (`mem_fill`=1, `mem_write`=0, `mem_addr` line-aligned and physical). It returns the requested data from the line and installs the line, so later reads of it hit.
- R6: `req_size` 0 is a byte, 1 is a halfword and 2 is a longword. Data is right-aligned and zero-extended. Lanes are little-endian: the byte at line offset k sits in line bits 8k+7:8k.
- R7: Every cached write is sent to memory as one single write. A write hit also merges the new bytes into the cached line. A write miss leaves the cache unchanged, so a later read of that line still fills.
- R8: Any access with code 010 clears the valid bit of every way in the indexed set whose tag matches. It completes in the cycle after acceptance, with no memory access and read data 0.
- R9: Code 011 accesses the tag array: way = bits 11:10, set = bits 9:4. The word holds the tag in bits 28:10, the set's 6-bit LRU state in 9:4 and the valid bit in bit 2, with the rest 0. Writes load all three fields, and the access completes with no memory access.
- R10: Code 110 accesses the data array: way = bits 11:10, set = bits 9:4, offset = bits 3:0. Sizes and lanes follow R6, and there is no memory access.
- R11: A fill replaces the lowest-numbered invalid way if one exists. Otherwise it replaces the least recently used way. Every hit and every fill makes its way the most recently used.
- R12: After reset all lines are invalid, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R13: While memory has not acknowledged, `mem_req` stays high with a stable address and `req_ready` stays low. Write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Enables caching for code 000, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and purges |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_write | output | 1 | Memory access is a write |
| mem_fill | output | 1 | Memory access is a whole-line read |
| mem_addr | output | 32 | Memory byte address, line-aligned for fills |
| mem_size | output | 2 | Size of a single access |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 128 | Line for fills; longword containing the address in bits 31:0 for single reads |

## Verification
On every cycle the assertions check the memory handshake: the request is held with a stable address until acknowledged, and `req_ready` is low only while memory is pending. They also check that fills are aligned physical reads, that uncached codes reach memory without a fill, and that purges and direct array accesses finish one cycle after acceptance without memory traffic. Whether data is correct, whether a line truly hits after a fill, a write-through merge, a purge or a tag write, and which way a replacement evicts can only be shown by the bench. Its scenarios compare each response with a memory model and count fills and single accesses around each step.

// File: rtl/pcache4.sv
module pcache4 #(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cache_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [31:0]             req_addr,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    mem_req,
  output logic                    mem_write,
  output logic                    mem_fill,
  output logic [31:0]             mem_addr,
  output logic [1:0]              mem_size,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int WAYS   = 4;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int TAG_W  = 29 - TAG_LO;
  localparam int LINE_W = LINE_BYTES * 8;

  logic              s1_v, s1_wr, s1_cen;
  logic [31:0]       s1_addr, s1_wdata;
  logic [1:0]        s1_size;

  logic [TAG_W-1:0]  tag_q [WAYS][SETS];
  logic [LINE_W-1:0] dat_q [WAYS][SETS];
  logic [SETS-1:0]   val_q [WAYS];
  logic [5:0]        lru_q [SETS];

  function automatic logic [5:0] lru_touch(input logic [5:0] s, input logic [1:0] w);
    logic [5:0] r;
    r = s;
    case (w)
      2'd0: r[2:0] = 3'b111;
      2'd1: begin r[0] = 1'b0; r[3] = 1'b1; r[4] = 1'b1; end
      2'd2: begin r[1] = 1'b0; r[3] = 1'b0; r[5] = 1'b1; end
      default: begin r[2] = 1'b0; r[4] = 1'b0; r[5] = 1'b0; end
    endcase
    return r;
  endfunction

  function automatic logic [1:0] lru_oldest(input logic [5:0] s);
    if (s[2:0] == 3'b000)             return 2'd0;
    if (s[0] && !s[3] && !s[4])       return 2'd1;
    if (s[1] && s[3] && !s[5])        return 2'd2;
    if (s[2] && s[4] && s[5])         return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] l,
                                               input logic [OFF_W-1:0] off,
                                               input logic [1:0] sz,
                                               input logic [31:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    case (sz)
      2'd0:    r[int'(off) * 8 +: 8] = d[7:0];
      2'd1:    r[int'(off[OFF_W-1:1]) * 16 +: 16] = d[15:0];
      default: r[int'(off[OFF_W-1:2]) * 32 +: 32] = d;
    endcase
    return r;
  endfunction

  wire [2:0]       part = s1_addr[31:29];
  wire [IDX_W-1:0] idx  = s1_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tagf = s1_addr[28:TAG_LO];
  wire [1:0]       wsel = s1_addr[TAG_LO +: 2];

  wire p_cache = (part == 3'b000) && s1_cen;
  wire p_purge = (part == 3'b010);
  wire p_tag   = (part == 3'b011);
  wire p_data  = (part == 3'b110);
  wire p_unc   = !(p_cache || p_purge || p_tag || p_data);

  logic [WAYS-1:0] hitv;
  logic [1:0]      hway, vict;

  always_comb begin
    hitv = '0;
    hway = 2'd0;
    vict = lru_oldest(lru_q[idx]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      hitv[w] = val_q[w][idx] && (tag_q[w][idx] == tagf);
      if (hitv[w]) hway = 2'(w);
      if (!val_q[w][idx]) vict = 2'(w);
    end
  end

  wire hit       = |hitv;
  wire needs_mem = p_unc || (p_cache && (s1_wr || !hit));
  wire done      = s1_v && (!needs_mem || mem_ack);
  wire [31:0] phys = (part[2:1] == 2'b00) ? {3'b000, s1_addr[28:0]} : s1_addr;

  assign req_ready = !s1_v || done;
  assign mem_req   = s1_v && needs_mem;
  assign mem_write = s1_wr;
  assign mem_fill  = p_cache && !s1_wr;
  assign mem_addr  = mem_fill ? {phys[31:OFF_W], {OFF_W{1'b0}}} : phys;
  assign mem_size  = s1_size;
  assign mem_wdata = s1_wdata;
  assign rsp_valid = done;

  logic [LINE_W-1:0] src_line;
  logic [31:0]       lw, ext, tword;

  always_comb begin
    if (p_data)   src_line = dat_q[wsel][idx];
    else if (hit) src_line = dat_q[hway][idx];
    else          src_line = mem_rdata;
    lw = p_unc ? mem_rdata[31:0] : src_line[int'(s1_addr[OFF_W-1:2]) * 32 +: 32];
    case (s1_size)
      2'd0:    ext = {24'b0, lw[int'(s1_addr[1:0]) * 8 +: 8]};
      2'd1:    ext = {16'b0, lw[int'(s1_addr[1]) * 16 +: 16]};
      default: ext = lw;
    endcase
    tword = '0;
    tword[28:TAG_LO] = tag_q[wsel][idx];
    tword[9:4]       = lru_q[idx];
    tword[2]         = val_q[wsel][idx];
  end

  assign rsp_rdata = (s1_wr || p_purge) ? 32'b0 : (p_tag ? tword : ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         s1_v <= 1'b0;
    else if (req_ready) s1_v <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_ready && req_valid) begin
      s1_addr  <= req_addr;
      s1_wr    <= req_write;
      s1_size  <= req_size;
      s1_wdata <= req_wdata;
      s1_cen   <= cache_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) val_q[w] <= '0;
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (done) begin
      if (p_cache && !s1_wr) begin
        if (hit) lru_q[idx] <= lru_touch(lru_q[idx], hway);
        else begin
          val_q[vict][idx] <= 1'b1;
          lru_q[idx]       <= lru_touch(lru_q[idx], vict);
        end
      end
      if (p_cache && s1_wr && hit) lru_q[idx] <= lru_touch(lru_q[idx], hway);
      if (p_purge)
        for (int w = 0; w < WAYS; w++)
          if (hitv[w]) val_q[w][idx] <= 1'b0;
      if (p_tag && s1_wr) begin
        val_q[wsel][idx] <= s1_wdata[2];
        lru_q[idx]       <= s1_wdata[9:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      if (p_cache && !s1_wr && !hit) begin
        tag_q[vict][idx] <= tagf;
        dat_q[vict][idx] <= mem_rdata;
      end
      if (p_cache && s1_wr && hit)
        dat_q[hway][idx] <= merge(dat_q[hway][idx], s1_addr[OFF_W-1:0], s1_size, s1_wdata);
      if (p_tag && s1_wr) tag_q[wsel][idx] <= s1_wdata[28:TAG_LO];
      if (p_data && s1_wr)
        dat_q[wsel][idx] <= merge(dat_q[wsel][idx], s1_addr[OFF_W-1:0], s1_size, s1_wdata);
    end
  end
endmodule

module pcache4_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        mem_req,
  input logic        mem_write,
  input logic        mem_fill,
  input logic [31:0] mem_addr,
  input logic        mem_ack
);
  wire acc = req_valid && req_ready;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R13
  stall_only_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> mem_req && !mem_ack);

  // R8
  purge_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr[31:29] == 3'b010 |=> rsp_valid && !mem_req);

  // R9 R10
  direct_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_addr[31:29] == 3'b011 || req_addr[31:29] == 3'b110) |=> rsp_valid && !mem_req);

  // R5
  fill_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_fill |-> mem_addr[3:0] == 4'h0 && !mem_write && mem_addr[31:29] == 3'b000);

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_addr[31:29] == 3'b001 || req_addr[31:29] == 3'b111) |=> mem_req && !mem_fill);
endmodule

bind pcache4 pcache4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .mem_req(mem_req),
  .mem_write(mem_write), .mem_fill(mem_fill), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/pcache4_tb.sv
module pcache4_tb;
  logic clk = 1'b0, rst_n = 1'b0, cache_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, mem_ack = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_size = 2'd2;
  logic req_ready, rsp_valid, mem_req, mem_write, mem_fill;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pcache4 u_dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_fill(mem_fill),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  int n_fill = 0, n_rd = 0, n_wr = 0, wcnt = 0, run = 0;
  bit prev_rsp = 1'b0;
  logic [31:0] last_maddr = '0;
  logic [31:0] mem_m [int unsigned];

  typedef struct { logic [31:0] d; string r; } exp_t;
  exp_t sbq[$];

  function automatic logic [31:0] wordval(input logic [31:0] ba);
    int unsigned k;
    k = int'(ba >> 2);
    if (mem_m.exists(k)) return mem_m[k];
    return 32'(k) * 32'h0101_0007 + 32'h3C00_00A5;
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'b0, w[int'(a[1:0]) * 8 +: 8]};
      2'd1:    return {16'b0, w[int'(a[1]) * 16 +: 16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] phys(input logic [31:0] a);
    return (a[31:30] == 2'b00) ? {3'b000, a[28:0]} : a;
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, input string r,
                        input bit use_x, input logic [31:0] xv);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr || a[31:29] == 3'b010) e.d = 32'b0;
    else if (use_x)               e.d = xv;
    else                          e.d = extract(wordval(phys(a)), a, sz);
    e.r = r;
    sbq.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(posedge clk);
    while (sbq.size() != 0 || mem_req) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (rst_n && mem_req) begin
      if (wcnt == 1) begin
        logic [31:0] w;
        wcnt = 0;
        mem_ack <= 1'b1;
        last_maddr = mem_addr;
        if (mem_write) begin
          n_wr++;
          w = wordval(mem_addr);
          case (mem_size)
            2'd0:    w[int'(mem_addr[1:0]) * 8 +: 8] = mem_wdata[7:0];
            2'd1:    w[int'(mem_addr[1]) * 16 +: 16] = mem_wdata[15:0];
            default: w = mem_wdata;
          endcase
          mem_m[int'(mem_addr >> 2)] = w;
        end else if (mem_fill) begin
          n_fill++;
          for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = wordval(mem_addr + 32'(4 * k));
        end else begin
          n_rd++;
          mem_rdata = {96'b0, wordval(mem_addr)};
        end
      end else wcnt++;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (rsp_valid) begin
        run = prev_rsp ? run + 1 : 1;
        if (sbq.size() == 0) check(1'b0, "R4 unexpected response", rsp_rdata, 32'b0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          check(rsp_rdata === e.d, e.r, rsp_rdata, e.d);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R13 watchdog: actual=%h expected=%h", 32'hdead, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int f0, r0, m0;
    logic [31:0] A, B;
    A = 32'h0000_1230;
    B = 32'h0000_5670;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R12 reset state",
          {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

    f0 = n_fill;
    access(A, 0, 2, 0, "R5 miss read data", 0, 0);
    check(mem_req === 1'b1 && req_ready === 1'b0, "R13 stall while filling", {30'b0, mem_req, req_ready}, 32'h2);
    check(mem_fill === 1'b1 && mem_addr === 32'h0000_1230, "R5 fill address", mem_addr, 32'h0000_1230);
    drain();
    check(n_fill == f0 + 1, "R5 one fill", 32'(n_fill - f0), 32'd1);

    f0 = n_fill;
    access(A + 5, 0, 0, 0, "R6 byte lane", 0, 0);
    access(A + 6, 0, 1, 0, "R6 halfword lane", 0, 0);
    access(A + 8, 0, 2, 0, "R6 longword", 0, 0);
    drain();
    check(n_fill == f0, "R3 hits need no fill", 32'(n_fill - f0), 32'd0);

    m0 = n_fill + n_rd + n_wr;
    access(A,      0, 2, 0, "R4 burst 0", 0, 0);
    access(A + 4,  0, 2, 0, "R4 burst 1", 0, 0);
    access(A + 8,  0, 2, 0, "R4 burst 2", 0, 0);
    access(A + 12, 0, 2, 0, "R4 burst 3", 0, 0);
    drain();
    check(run >= 4, "R4 one response per cycle", 32'(run), 32'd4);
    check(n_fill + n_rd + n_wr == m0, "R4 no memory on hits", 32'(n_fill + n_rd + n_wr - m0), 32'd0);

    f0 = n_fill; r0 = n_wr;
    access(A + 4, 1, 2, 32'hDEAD_BEEF, "R13 write response zero", 0, 0);
    access(A + 9, 1, 0, 32'h0000_0077, "R13 write response zero", 0, 0);
    drain();
    check(n_wr == r0 + 2, "R7 writes reach memory", 32'(n_wr - r0), 32'd2);
    access(A + 4, 0, 2, 0, "R7 hit line updated", 1, 32'hDEAD_BEEF);
    access(A + 8, 0, 2, 0, "R7 byte merged", 0, 0);
    drain();
    check(n_fill == f0, "R7 write hit keeps line", 32'(n_fill - f0), 32'd0);

    access(B, 1, 2, 32'h1357_9BDF, "R7 miss write response", 0, 0);
    drain();
    f0 = n_fill;
    access(B, 0, 2, 0, "R7 data after miss write", 1, 32'h1357_9BDF);
    drain();
    check(n_fill == f0 + 1, "R7 write miss allocates nothing", 32'(n_fill - f0), 32'd1);

    r0 = n_rd; f0 = n_fill;
    access(32'h2000_1234, 0, 2, 0, "R1 cache-through shares space", 1, 32'hDEAD_BEEF);
    drain();
    check(n_rd == r0 + 1 && n_fill == f0, "R1 cache-through single read", 32'(n_rd - r0), 32'd1);
    check(last_maddr === 32'h0000_1234, "R2 cache-through physical address", last_maddr, 32'h0000_1234);

    cache_en = 1'b0;
    r0 = n_rd;
    access(A, 0, 2, 0, "R1 disabled read data", 0, 0);
    drain();
    check(n_rd == r0 + 1, "R1 disabled is uncached", 32'(n_rd - r0), 32'd1);
    cache_en = 1'b1;

    access(32'hE000_0010, 0, 2, 0, "R1 io read", 0, 0);
    drain();
    check(last_maddr === 32'hE000_0010, "R2 io address unchanged", last_maddr, 32'hE000_0010);
    r0 = n_rd; f0 = n_fill;
    access(32'h8000_0020, 0, 1, 0, "R1 code 100 read", 0, 0);
    drain();
    check(n_rd == r0 + 1 && n_fill == f0, "R1 code 100 uncached", 32'(n_rd - r0), 32'd1);

    m0 = n_fill + n_rd + n_wr;
    access(32'h4000_1230, 1, 2, 0, "R8 purge response", 0, 0);
    drain();
    check(n_fill + n_rd + n_wr == m0, "R8 purge without memory", 32'(n_fill + n_rd + n_wr - m0), 32'd0);
    f0 = n_fill;
    access(A, 0, 2, 0, "R8 read after purge", 0, 0);
    drain();
    check(n_fill == f0 + 1, "R8 purged line refetched", 32'(n_fill - f0), 32'd1);

    access(32'h6000_0230, 0, 2, 0, "R9 tag word way0", 1, 32'h0000_1074);
    access(32'hC000_0630, 1, 2, 32'hCAFE_F00D, "R10 data write response", 0, 0);
    access(32'hC000_0631, 0, 0, 0, "R10 data byte read", 1, 32'h0000_00F0);
    access(32'h6000_0630, 1, 2, 32'h0000_2474, "R9 tag write response", 0, 0);
    drain();
    f0 = n_fill;
    access(32'h0000_2630, 0, 2, 0, "R9 hit through written tag", 1, 32'hCAFE_F00D);
    drain();
    check(n_fill == f0, "R9 written tag hits", 32'(n_fill - f0), 32'd0);
    access(32'h6000_0630, 1, 2, 32'h0000_2470, "R9 tag invalidate response", 0, 0);
    access(32'h0000_2630, 0, 2, 0, "R9 read after invalidate", 0, 0);
    drain();
    check(n_fill == f0 + 1, "R9 invalid way misses", 32'(n_fill - f0), 32'd1);

    f0 = n_fill;
    access(32'h0000_0500, 0, 2, 0, "R11 fill tag1", 0, 0);
    access(32'h0000_0900, 0, 2, 0, "R11 fill tag2", 0, 0);
    access(32'h0000_0D00, 0, 2, 0, "R11 fill tag3", 0, 0);
    access(32'h0000_1100, 0, 2, 0, "R11 fill tag4", 0, 0);
    access(32'h0000_0500, 0, 2, 0, "R11 hit tag1", 0, 0);
    access(32'h0000_1500, 0, 2, 0, "R11 fill tag5", 0, 0);
    drain();
    check(n_fill == f0 + 5, "R11 fill count", 32'(n_fill - f0), 32'd5);
    access(32'h6000_0500, 0, 2, 0, "R11 victim is way1", 1, 32'h0000_15E4);
    drain();
    f0 = n_fill;
    access(32'h0000_0900, 0, 2, 0, "R11 evicted line data", 0, 0);
    access(32'h0000_0500, 0, 2, 0, "R11 recent line data", 0, 0);
    drain();
    check(n_fill == f0 + 1, "R11 only evicted line refills", 32'(n_fill - f0), 32'd1);

    check(sbq.size() == 0, "R4 all responses seen", 32'(sbq.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule